// File: doc/BRIEF.md
# Script Instruction Prefetch Buffer

This block keeps a small queue of instruction dwords ahead of the point where a script-driven DMA engine is executing. It reads consecutive dwords from a simple tagged memory read port and offers the oldest one to the instruction decoder through a valid/ready pair. It also reports the address that dword came from. Up to `DEPTH` dwords, counting those held and those still being fetched, are kept ahead of execution.

Some execution events make the queued dwords stale. When one occurs, the queue is emptied and fetching restarts at the correct address. These events are: a store that does not carry its keep option, a write to the script pointer, a branch whose condition is met, and a self-clearing flush bit in the control register. Every request carries an epoch tag, and the epoch advances on each flush, so memory responses that were already in flight are discarded when they arrive. When the prefetch enable input is low, the block fetches one dword at a time and only when the decoder has nothing left to take.

Top module: `script_prefetch_buf`

## Requirements
- R1: Dwords reach the decoder in address order, each 4 bytes above the previous one. `instr_addr_o` gives the address of the head dword and `instr_data_o` gives the data memory returned for it. A pop happens on any cycle where `instr_valid_o` and `instr_ready_i` are both high.
- R2: With prefetch enabled, the held dwords plus the outstanding requests never exceed `DEPTH`. With no pops, exactly `DEPTH` requests are issued after a restart.
- R3: A store with `st_keep_i` low empties the queue at that clock edge, and fetching restarts at the next dword the decoder has not yet taken. A store with `st_keep_i` high leaves the contents and the valid head unchanged.
- R4: A script pointer write empties the queue, and the next head dword comes from the written address. If a pointer write and a taken branch occur in the same cycle, the written address wins.
- R5: A branch with `br_taken_i` high empties the queue and restarts at `br_target_i`. A branch with `br_taken_i` low has no effect on the queue.
- R6: A control write with bit 6 of `ctl_wdata_i` set sets the flush bit. The flush bit reads back as 1 for exactly one cycle and then clears itself. While the bit is set, the queue is emptied. A control write with bit 6 clear does nothing.
- R7: After a flush, the first head dword is the restart address. Responses to requests issued before the flush are never delivered.
- R8: If a flush and a pop happen in the same cycle, the flush wins and `instr_valid_o` is low in the next cycle. A store or flush-bit restart then resumes just after the popped dword.
- R9: With `pf_en_i` low, a request is issued only when no dword is held and none is outstanding. At most one dword is therefore fetched per pop.
- R10: During reset, `instr_valid_o`, `mem_req_valid_o` and `flush_bit_o` are low. The first request after reset goes to `RESET_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_en_i | input | 1 | 1: prefetch ahead; 0: fetch on demand only |
| ptr_wr_i | input | 1 | Script pointer register write strobe |
| ptr_wdata_i | input | ADDR_W | New script pointer value |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | CTL_W | Control register write data; bit 6 requests a flush |
| br_exec_i | input | 1 | A transfer-control instruction is executing |
| br_taken_i | input | 1 | Its condition is true |
| br_target_i | input | ADDR_W | Branch target address |
| st_exec_i | input | 1 | A store instruction is executing |
| st_keep_i | input | 1 | The store carries the keep-contents option |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Read address |
| mem_req_tag_o | output | EPOCH_W | Epoch tag of the request |
| mem_rsp_valid_i | input | 1 | Read response valid (responses return in order) |
| mem_rsp_data_i | input | DATA_W | Read data |
| mem_rsp_tag_i | input | EPOCH_W | Tag echoed with the response |
| instr_valid_o | output | 1 | Head dword valid |
| instr_ready_i | input | 1 | Decoder takes the head dword |
| instr_data_o | output | DATA_W | Head dword |
| instr_addr_o | output | ADDR_W | Address of the head dword |
| flush_bit_o | output | 1 | Read-back of the self-clearing flush bit |

## Verification
The bench builds the block with `DEPTH` 8, `EPOCH_W` 2 and `RESET_ADDR` 0x400. It pairs the block with a memory model that accepts every request and answers two cycles later. Because of that latency, there are always requests in flight when a flush arrives close to a restart, which makes discarding stale responses observable. An eight-entry queue fills within about a dozen cycles, so the bench can check the exact request count against the slot limit. A nonzero reset address shows that the first fetch really comes from the parameter.

// File: rtl/spf_pkg.sv
package spf_pkg;

   // Source of a queue invalidation, in priority order
   typedef enum logic [2:0] {
      FLS_NONE   = 3'd0,
      FLS_PTR    = 3'd1,
      FLS_BRANCH = 3'd2,
      FLS_STORE  = 3'd3,
      FLS_CTRL   = 3'd4
   } flush_src_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/spf_queue.sv
module spf_queue #(
   parameter  int DATA_W = 32,
   parameter  int DEPTH  = 8,
   localparam int AW     = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic [CNT_W-1:0]  occ
);

   logic [DEPTH-1:0][DATA_W-1:0] slots_q;
   logic [AW-1:0]                wr_ptr_q;
   logic [AW-1:0]                rd_ptr_q;
   logic [CNT_W-1:0]             occ_q;
   logic                         do_push;
   logic                         do_pop;

   // a clear overrides both sides
   assign do_push = push && !clr;
   assign do_pop  = pop && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         occ_q    <= '0;
      end else if (clr) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         occ_q    <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_q + AW'(1);
         if (do_pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
         occ_q <= occ_q + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slots_q[wr_ptr_q] <= push_data;
   end

   assign head_data = slots_q[rd_ptr_q];
   assign occ       = occ_q;

   AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (occ_q < CNT_W'(DEPTH))); // R2
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (occ_q != '0)); // R1

endmodule

// File: rtl/spf_fetch_ctrl.sv
module spf_fetch_ctrl #(
   parameter  int              ADDR_W     = 32,
   parameter  int              DEPTH      = 8,
   parameter  int              EPOCH_W    = 2,
   parameter  int              STEP       = 4,
   parameter  logic [ADDR_W-1:0] RESET_ADDR = '0,
   localparam int              CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pf_en,
   input  logic               flush,
   input  logic [ADDR_W-1:0]  restart_addr,
   input  logic [CNT_W-1:0]   occ,
   input  logic               req_ready,
   input  logic               rsp_valid,
   input  logic [EPOCH_W-1:0] rsp_tag,
   output logic               req_valid,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [EPOCH_W-1:0] req_tag,
   output logic               rsp_accept,
   output logic [CNT_W-1:0]   outst
);

   logic               run_q;
   logic [ADDR_W-1:0]  fetch_addr_q;
   logic [EPOCH_W-1:0] epoch_q;
   logic [CNT_W-1:0]   outst_q;
   logic [CNT_W:0]     reserved;
   logic               room;
   logic               fire;

   assign reserved = {1'b0, occ} + {1'b0, outst_q};

   // prefetch keeps every slot reserved; demand mode waits for an idle queue
   always_comb begin
      if (pf_en) room = (reserved < (CNT_W + 1)'(DEPTH));
      else       room = (reserved == '0);
   end

   assign req_valid  = run_q && !flush && room;
   assign fire       = req_valid && req_ready;
   assign rsp_accept = rsp_valid && (rsp_tag == epoch_q) && !flush;
   assign req_addr   = fetch_addr_q;
   assign req_tag    = epoch_q;
   assign outst      = outst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q        <= 1'b0;
         fetch_addr_q <= RESET_ADDR;
         epoch_q      <= '0;
         outst_q      <= '0;
      end else begin
         run_q <= 1'b1;
         if (flush) begin
            fetch_addr_q <= restart_addr;
            epoch_q      <= epoch_q + EPOCH_W'(1);
            outst_q      <= '0;
         end else begin
            if (fire) fetch_addr_q <= fetch_addr_q + ADDR_W'(STEP);
            outst_q <= outst_q + CNT_W'(fire) - CNT_W'(rsp_accept);
         end
      end
   end

   AST_RSP_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_accept |-> (outst_q != '0)); // R7
   AST_EPOCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (epoch_q != $past(epoch_q))); // R7

endmodule

// File: rtl/spf_flush_ctrl.sv
module spf_flush_ctrl
   import spf_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CTL_W     = 8,
   parameter int FLUSH_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr,
   input  logic [ADDR_W-1:0] ptr_wdata,
   input  logic              br_exec,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              st_exec,
   input  logic              st_keep,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic [ADDR_W-1:0] resume_addr,
   output logic              flush,
   output logic [ADDR_W-1:0] restart_addr,
   output logic              flush_bit
);

   logic       flush_bit_q;
   flush_src_e src;
   logic       unused_ctl_bits;

   assign unused_ctl_bits = ^ctl_wdata;

   // set by a write, clears itself one cycle later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_bit_q <= 1'b0;
      else        flush_bit_q <= ctl_wr && ctl_wdata[FLUSH_BIT] && !flush_bit_q;
   end

   always_comb begin
      if (ptr_wr)                    src = FLS_PTR;
      else if (br_exec && br_taken)  src = FLS_BRANCH;
      else if (st_exec && !st_keep)  src = FLS_STORE;
      else if (flush_bit_q)          src = FLS_CTRL;
      else                           src = FLS_NONE;
   end

   always_comb begin
      unique case (src)
         FLS_PTR:    restart_addr = ptr_wdata;
         FLS_BRANCH: restart_addr = br_target;
         default:    restart_addr = resume_addr;
      endcase
   end

   assign flush     = (src != FLS_NONE);
   assign flush_bit = flush_bit_q;

   AST_FLUSH_BIT_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
      flush_bit_q |=> !flush_bit_q); // R6

endmodule

// File: rtl/script_prefetch_buf.sv
module script_prefetch_buf
   import spf_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              DATA_W     = 32,
   parameter int              DEPTH      = 8,
   parameter int              EPOCH_W    = 2,
   parameter int              CTL_W      = 8,
   parameter int              FLUSH_BIT  = 6,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pf_en_i,
   input  logic               ptr_wr_i,
   input  logic [ADDR_W-1:0]  ptr_wdata_i,
   input  logic               ctl_wr_i,
   input  logic [CTL_W-1:0]   ctl_wdata_i,
   input  logic               br_exec_i,
   input  logic               br_taken_i,
   input  logic [ADDR_W-1:0]  br_target_i,
   input  logic               st_exec_i,
   input  logic               st_keep_i,
   output logic               mem_req_valid_o,
   input  logic               mem_req_ready_i,
   output logic [ADDR_W-1:0]  mem_req_addr_o,
   output logic [EPOCH_W-1:0] mem_req_tag_o,
   input  logic               mem_rsp_valid_i,
   input  logic [DATA_W-1:0]  mem_rsp_data_i,
   input  logic [EPOCH_W-1:0] mem_rsp_tag_i,
   output logic               instr_valid_o,
   input  logic               instr_ready_i,
   output logic [DATA_W-1:0]  instr_data_o,
   output logic [ADDR_W-1:0]  instr_addr_o,
   output logic               flush_bit_o
);

   localparam int STEP  = DATA_W / 8;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be a whole number of bytes");
   end
   if (FLUSH_BIT >= CTL_W) begin : g_bad_flush_bit
      $error("FLUSH_BIT outside the control register");
   end
   if (EPOCH_W < 1) begin : g_bad_epoch
      $error("EPOCH_W must be at least 1");
   end

   logic              flush;
   logic [ADDR_W-1:0] restart_addr;
   logic [ADDR_W-1:0] head_addr_q;
   logic [ADDR_W-1:0] resume_addr;
   logic [CNT_W-1:0]  occ;
   logic [CNT_W-1:0]  outst;
   logic              rsp_accept;
   logic              pop;

   assign instr_valid_o = (occ != '0);
   assign pop           = instr_valid_o && instr_ready_i;
   // next dword the decoder has not taken yet
   assign resume_addr   = pop ? head_addr_q + ADDR_W'(STEP) : head_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     head_addr_q <= RESET_ADDR;
      else if (flush) head_addr_q <= restart_addr;
      else if (pop)   head_addr_q <= head_addr_q + ADDR_W'(STEP);
   end

   assign instr_addr_o = head_addr_q;

   spf_flush_ctrl #(
      .ADDR_W    (ADDR_W),
      .CTL_W     (CTL_W),
      .FLUSH_BIT (FLUSH_BIT)
   ) u_flush (
      .clk          (clk),
      .rst_n        (rst_n),
      .ptr_wr       (ptr_wr_i),
      .ptr_wdata    (ptr_wdata_i),
      .br_exec      (br_exec_i),
      .br_taken     (br_taken_i),
      .br_target    (br_target_i),
      .st_exec      (st_exec_i),
      .st_keep      (st_keep_i),
      .ctl_wr       (ctl_wr_i),
      .ctl_wdata    (ctl_wdata_i),
      .resume_addr  (resume_addr),
      .flush        (flush),
      .restart_addr (restart_addr),
      .flush_bit    (flush_bit_o)
   );

   spf_fetch_ctrl #(
      .ADDR_W     (ADDR_W),
      .DEPTH      (DEPTH),
      .EPOCH_W    (EPOCH_W),
      .STEP       (STEP),
      .RESET_ADDR (RESET_ADDR)
   ) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .pf_en        (pf_en_i),
      .flush        (flush),
      .restart_addr (restart_addr),
      .occ          (occ),
      .req_ready    (mem_req_ready_i),
      .rsp_valid    (mem_rsp_valid_i),
      .rsp_tag      (mem_rsp_tag_i),
      .req_valid    (mem_req_valid_o),
      .req_addr     (mem_req_addr_o),
      .req_tag      (mem_req_tag_o),
      .rsp_accept   (rsp_accept),
      .outst        (outst)
   );

   spf_queue #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (flush),
      .push      (rsp_accept),
      .push_data (mem_rsp_data_i),
      .pop       (pop),
      .head_data (instr_data_o),
      .occ       (occ)
   );

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, occ} + {1'b0, outst}) <= (CNT_W + 1)'(DEPTH)); // R2
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !instr_valid_o); // R8
   AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr_i |=> (instr_addr_o == $past(ptr_wdata_i))); // R4
   AST_BRANCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (br_exec_i && br_taken_i && !ptr_wr_i) |=> (instr_addr_o == $past(br_target_i))); // R5
   AST_DEMAND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pf_en_i && mem_req_valid_o && mem_req_ready_i) |=> (({1'b0, occ} + {1'b0, outst}) == (CNT_W + 1)'(1))); // R9

endmodule

// File: tb/tb_script_prefetch_buf.sv
`timescale 1ns/1ps
module tb_script_prefetch_buf;

   localparam logic [31:0] RST_A = 32'h0000_0400;
   localparam logic [31:0] KEY   = 32'h5A5A_0000;
   localparam int          DEPTH = 8;

   localparam logic [2:0] OP_POP   = 3'd0;
   localparam logic [2:0] OP_STK   = 3'd1; // store, keep option
   localparam logic [2:0] OP_ST    = 3'd2; // store, flushing
   localparam logic [2:0] OP_BRNT  = 3'd3;
   localparam logic [2:0] OP_BRT   = 3'd4;
   localparam logic [2:0] OP_PTR   = 3'd5;
   localparam logic [2:0] OP_CTL   = 3'd6;
   localparam logic [2:0] OP_CTLNB = 3'd7; // control write, bit 6 clear

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] arg;
      logic [31:0] exp_addr;
      logic        exp_v;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{OP_POP,   32'h0,      32'h0000_0404, 1'b1, 4'd1},  // R1
      '{OP_POP,   32'h0,      32'h0000_0408, 1'b1, 4'd1},  // R1
      '{OP_STK,   32'h0,      32'h0000_0408, 1'b1, 4'd3},  // R3 keep
      '{OP_ST,    32'h0,      32'h0000_0408, 1'b0, 4'd3},  // R3 flush
      '{OP_BRNT,  32'h900,    32'h0000_0408, 1'b1, 4'd5},  // R5 not taken
      '{OP_BRT,   32'h900,    32'h0000_0900, 1'b0, 4'd5},  // R5 taken
      '{OP_POP,   32'h0,      32'h0000_0904, 1'b1, 4'd1},  // R1
      '{OP_PTR,   32'h2000,   32'h0000_2000, 1'b0, 4'd4},  // R4
      '{OP_CTL,   32'h40,     32'h0000_2000, 1'b0, 4'd6},  // R6
      '{OP_CTLNB, 32'hBF,     32'h0000_2000, 1'b1, 4'd6},  // R6 bit clear
      '{OP_PTR,   32'h3000,   32'h0000_3000, 1'b0, 4'd4}   // R4
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pf_en = 1'b1;
   logic        ptr_wr = 1'b0;
   logic [31:0] ptr_wdata = '0;
   logic        ctl_wr = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic        br_exec = 1'b0, br_taken = 1'b0;
   logic [31:0] br_target = '0;
   logic        st_exec = 1'b0, st_keep = 1'b0;
   logic        req_valid;
   logic [31:0] req_addr;
   logic [1:0]  req_tag;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic [1:0]  rsp_tag;
   logic        instr_valid;
   logic        instr_ready = 1'b0;
   logic [31:0] instr_data;
   logic [31:0] instr_addr;
   logic        flush_bit;

   int n_tests = 0;
   int n_fail  = 0;
   int nreq    = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   script_prefetch_buf #(
      .DEPTH      (DEPTH),
      .EPOCH_W    (2),
      .RESET_ADDR (RST_A)
   ) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .pf_en_i         (pf_en),
      .ptr_wr_i        (ptr_wr),
      .ptr_wdata_i     (ptr_wdata),
      .ctl_wr_i        (ctl_wr),
      .ctl_wdata_i     (ctl_wdata),
      .br_exec_i       (br_exec),
      .br_taken_i      (br_taken),
      .br_target_i     (br_target),
      .st_exec_i       (st_exec),
      .st_keep_i       (st_keep),
      .mem_req_valid_o (req_valid),
      .mem_req_ready_i (1'b1),
      .mem_req_addr_o  (req_addr),
      .mem_req_tag_o   (req_tag),
      .mem_rsp_valid_i (rsp_valid),
      .mem_rsp_data_i  (rsp_data),
      .mem_rsp_tag_i   (rsp_tag),
      .instr_valid_o   (instr_valid),
      .instr_ready_i   (instr_ready),
      .instr_data_o    (instr_data),
      .instr_addr_o    (instr_addr),
      .flush_bit_o     (flush_bit)
   );

   // memory model: always ready, answers two cycles after acceptance
   logic        s0_v = 1'b0, s1_v = 1'b0;
   logic [31:0] s0_d = '0, s1_d = '0;
   logic [1:0]  s0_t = '0, s1_t = '0;
   always @(posedge clk) begin
      s0_v <= req_valid;
      s0_d <= req_addr ^ KEY;
      s0_t <= req_tag;
      s1_v <= s0_v;
      s1_d <= s0_d;
      s1_t <= s0_t;
      if (req_valid) nreq <= nreq + 1;
   end
   assign rsp_valid = s1_v;
   assign rsp_data  = s1_d;
   assign rsp_tag   = s1_t;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic do_event(input logic [2:0] op, input logic [31:0] arg);
      case (op)
         OP_POP:   instr_ready = 1'b1;
         OP_STK:   begin st_exec = 1'b1; st_keep = 1'b1; end
         OP_ST:    st_exec = 1'b1;
         OP_BRNT:  begin br_exec = 1'b1; br_target = arg; end
         OP_BRT:   begin br_exec = 1'b1; br_taken = 1'b1; br_target = arg; end
         OP_PTR:   begin ptr_wr = 1'b1; ptr_wdata = arg; end
         default:  begin ctl_wr = 1'b1; ctl_wdata = arg[7:0]; end
      endcase
      @(negedge clk);
      instr_ready = 1'b0; st_exec = 1'b0; st_keep = 1'b0;
      br_exec = 1'b0; br_taken = 1'b0; ptr_wr = 1'b0; ctl_wr = 1'b0;
   endtask

   task automatic wait_valid();
      for (int i = 0; i < 40; i++) begin
         if (instr_valid) break;
         @(negedge clk);
      end
   endtask

   task automatic chk_head(input logic [31:0] exp, input string tag);
      wait_valid();
      chk(instr_valid && instr_addr == exp, {tag, " head address"}, instr_addr, exp);
      chk(instr_data == (exp ^ KEY), {tag, " head data"}, instr_data, exp ^ KEY);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] h;
      int n0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!instr_valid, "R10 valid in reset", 32'(instr_valid), 32'h0);
      chk(!req_valid, "R10 request in reset", 32'(req_valid), 32'h0);
      chk(!flush_bit, "R10 flush bit in reset", 32'(flush_bit), 32'h0);
      rst_n = 1'b1;
      n0 = nreq;
      @(negedge clk);
      chk(req_valid && req_addr == RST_A, "R10 first request address", req_addr, RST_A);
      repeat (30) @(negedge clk);
      // R2 slot limit with no pops
      chk(nreq - n0 == DEPTH, "R2 requests issued when full", 32'(nreq - n0), 32'(DEPTH));
      chk_head(RST_A, "R1 after reset");

      // vector walk
      for (int i = 0; i < NV; i++) begin
         repeat (16) @(negedge clk);
         do_event(VECS[i].op, VECS[i].arg);
         @(negedge clk);
         chk(instr_valid == VECS[i].exp_v, $sformatf("R%0d vec %0d valid after event", VECS[i].req, i),
             32'(instr_valid), 32'(VECS[i].exp_v));
         chk_head(VECS[i].exp_addr, $sformatf("R%0d vec %0d", VECS[i].req, i));
      end

      // R6 self-clearing bit readback
      repeat (16) @(negedge clk);
      do_event(OP_CTL, 32'h40);
      chk(flush_bit, "R6 bit set after write", 32'(flush_bit), 32'h1);
      @(negedge clk);
      chk(!flush_bit, "R6 bit self-cleared", 32'(flush_bit), 32'h0);
      chk(!instr_valid, "R6 queue emptied", 32'(instr_valid), 32'h0);

      // R8 flush and pop together
      repeat (16) @(negedge clk);
      h = instr_addr;
      instr_ready = 1'b1;
      do_event(OP_ST, 32'h0);
      chk(!instr_valid, "R8 no valid after flush with pop", 32'(instr_valid), 32'h0);
      chk_head(h + 32'd4, "R8 restart after popped dword");

      // R7 stale responses dropped
      repeat (16) @(negedge clk);
      do_event(OP_PTR, 32'h5000);
      @(negedge clk);
      do_event(OP_BRT, 32'h7000);
      chk_head(32'h7000, "R7 first head after back-to-back flush");
      do_event(OP_POP, 32'h0);
      chk_head(32'h7004, "R7 second head");

      // R4 pointer write beats taken branch
      repeat (16) @(negedge clk);
      br_exec = 1'b1; br_taken = 1'b1; br_target = 32'h9000;
      do_event(OP_PTR, 32'h8000);
      chk_head(32'h8000, "R4 pointer write priority");

      // R9 demand-only fetching
      repeat (16) @(negedge clk);
      pf_en = 1'b0;
      do_event(OP_PTR, 32'h6000);
      n0 = nreq;
      repeat (20) @(negedge clk);
      chk(nreq - n0 == 1, "R9 one fetch while idle", 32'(nreq - n0), 32'h1);
      chk(!req_valid, "R9 no request while dword held", 32'(req_valid), 32'h0);
      chk_head(32'h6000, "R9 first demand dword");
      do_event(OP_POP, 32'h0);
      repeat (20) @(negedge clk);
      chk(nreq - n0 == 2, "R9 one fetch per pop", 32'(nreq - n0), 32'h2);
      chk_head(32'h6004, "R9 second demand dword");
      pf_en = 1'b1;
      repeat (20) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule